// File: doc/BRIEF.md
# VFD Grid Scan Sequencer

This block produces the control waveforms that refresh a 128 x 32 dot-matrix vacuum fluorescent display with interleaved columns. A frame has `STEPS` timing steps. Each step follows a fixed order. The grid is masked first, and then the latch is pulsed. Next the grid shift register is clocked once, with a serial token that is high on the first `TOKEN` steps, so that two neighbouring grids stay lit. After that, one of the two anode banks is unblanked according to the parity of the step, and the grid mask is released. Finally, a one-cycle start pulse tells an external anode shifter to load the data for the next step while the current columns are shown.

A programmable step timer sets the refresh rate. A step does not end until the timer has expired and the anode shifter has reported done. If the timer expires while the shifter is still busy, a sticky overrun flag is set. At each frame wrap the block emits a one-cycle vsync and increments a frame counter. While `enable` is low, all blanking lines are held high and the sequencer stays idle.

The controller has eight states:
- `SQ_IDLE` is the safe state. It goes to `SQ_MASK` when enabled.
- `SQ_MASK` lasts `SETTLE_CYC` cycles and goes to `SQ_LATCH`.
- `SQ_LATCH` lasts `LATCH_CYC` cycles and goes to `SQ_GCLK_LO`.
- `SQ_GCLK_LO` lasts `GCLK_CYC` cycles and goes to `SQ_GCLK_HI`.
- `SQ_GCLK_HI` lasts `GCLK_CYC` cycles and goes to `SQ_SELECT`.
- `SQ_SELECT` lasts `SETTLE_CYC` cycles and goes to `SQ_SHOW`.
- `SQ_SHOW` lasts one cycle and goes to `SQ_WAIT`.
- `SQ_WAIT` goes back to `SQ_MASK` once the timer has expired and the shifter is ready.

From any state, a low `enable` forces `SQ_IDLE` on the next cycle. Every entry into `SQ_MASK` starts a step.

Top module: `vfd_scan_seq`

## Requirements
In these requirements, step offset k counts cycles from 0, the first `SQ_MASK` cycle of a step. S = `SETTLE_CYC`, L = `LATCH_CYC` and C = `GCLK_CYC`.
- R1: From the cycle after `enable` goes low, these outputs hold until it rises again:
  - `grid_blank`, `bank1_blank` and `bank2_blank` are 1.
  - `latch`, `grid_data` and `anode_start` are 0, and `grid_clk` is 1.
  - `step_idx` reads 0, while `frame_count` keeps its value.
  - The cycle after `enable` rises is offset 0 of step 1.
- R2: `step_idx` takes the values 1..`STEPS` in order, one step after another, and wraps from `STEPS` to 1.
- R3: `grid_data` is 1 during every cycle of steps 1..`TOKEN` and 0 during all other steps.
- R4: For k < S, all three blanking lines are 1 and `latch` is 0. For S <= k < S+L, `latch` is 1 while all three blanking lines stay 1.
- R5: `grid_clk` is 0 exactly for S+L <= k < S+L+C and is 1 otherwise, giving one low pulse per step while the grid is masked.
- R6: From k = S+L+2C onward:
  - on odd steps `bank1_blank` is 0 and `bank2_blank` is 1;
  - on even steps the reverse holds;
  - both are never 0 together;
  - before that offset, both are 1.
- R7: `grid_blank` is 1 for k < 2S+L+2C and 0 from that offset to the end of the step. `anode_start` is 1 in exactly the cycle at that offset.
- R8: Let Q = 2S+L+2C+1, `step_reload` = R, and let `anode_done` pulse D >= 1 cycles after `anode_start`. The next step then starts max(R, Q-1+D)+1 cycles after the current one.
- R9: A step never advances before `anode_done` has been seen for its transfer. `overrun` becomes 1 when the timer has expired in `SQ_WAIT` while the shifter is still busy. Once set, it stays 1 until reset.
- R10: `vsync` is 1 for exactly one cycle, at offset 0 of step 1 after step `STEPS`, and is not asserted on the first step after enabling. `frame_count` increments by one in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the scan; low forces the safe idle state |
| step_reload | input | TIMER_W | Minimum step length minus one, in cycles |
| anode_done | input | 1 | One-cycle pulse from the anode shifter when its transfer ends |
| anode_start | output | 1 | One-cycle pulse that starts the anode transfer for the next step |
| grid_blank | output | 1 | Grid mask, high while switching |
| bank1_blank | output | 1 | Blanking for anode bank 1 (lit on odd steps) |
| bank2_blank | output | 1 | Blanking for anode bank 2 (lit on even steps) |
| latch | output | 1 | Anode latch pulse |
| grid_clk | output | 1 | Grid shift clock, idles high |
| grid_data | output | 1 | Grid serial token |
| vsync | output | 1 | Frame boundary strobe |
| frame_count | output | FRAME_W | Number of completed frame wraps |
| step_idx | output | STEP_W | Current step, 0 while idle |
| overrun | output | 1 | Sticky flag: step period elapsed while the shifter was busy |

## Verification
A controller stuck in the wrong state, or with a miscounted phase, moves the latch, grid-clock or unmask edges to the wrong step offset. The per-cycle offset model catches this within the same step. A wrong step counter shows up as a bad token, bad bank parity or a misplaced vsync, visible on the first step where it differs. A wrong handshake or timer shows as a step boundary that arrives early or late. The model's expected step index then disagrees in the very cycle the boundary should have occurred.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_MASK,
        SQ_LATCH,
        SQ_GCLK_LO,
        SQ_GCLK_HI,
        SQ_SELECT,
        SQ_SHOW,
        SQ_WAIT
    } scan_state_e;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/vfd_step_timer.sv
module vfd_step_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               load,
    input  logic [TIMER_W-1:0] reload,
    output logic               expired
);

    logic [TIMER_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R8: the count only moves down by one between loads
    a_r8_timer_down: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) || !enable)
        else $error("R8 timer did not count down");

endmodule

// File: rtl/vfd_step_counter.sv
module vfd_step_counter #(
    parameter int STEPS   = 64,
    parameter int STEP_W  = 7,
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               advance,
    output logic [STEP_W-1:0]  step_q,
    output logic               vsync_q,
    output logic [FRAME_W-1:0] frame_q
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS);
    localparam logic [STEP_W-1:0] FIRST_STEP = STEP_W'(1);

    logic wrap;
    assign wrap = advance && (step_q == LAST_STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (!enable) begin
            step_q <= '0;
        end else if (advance) begin
            step_q <= (step_q == LAST_STEP) ? FIRST_STEP : step_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync_q <= 1'b0;
            frame_q <= '0;
        end else begin
            vsync_q <= enable && wrap;
            if (enable && wrap) begin
                frame_q <= frame_q + 1'b1;
            end
        end
    end

    // R2: each new step follows the previous one, wrapping at the last
    a_r2_step_order: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && advance && step_q != '0) |=>
            (step_q == (($past(step_q) == LAST_STEP) ? FIRST_STEP : $past(step_q) + 1'b1)) || !enable)
        else $error("R2 step order broken");

    // R10: vsync marks the first step of a new frame and lasts one cycle
    a_r10_vsync_first: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_q |-> (step_q == FIRST_STEP) && ($past(step_q) == LAST_STEP))
        else $error("R10 vsync outside frame wrap");

    a_r10_vsync_single: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_q |=> !vsync_q)
        else $error("R10 vsync longer than one cycle");

endmodule

// File: rtl/vfd_anode_track.sv
module vfd_anode_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    input  logic stall,
    output logic ready,
    output logic overrun
);

    logic busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (stall) begin
            overrun <= 1'b1;
        end
    end

    assign ready = !busy_q || done;

    // R9: the overrun flag never clears outside reset
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overrun) |-> overrun)
        else $error("R9 overrun flag dropped");

    // R9: a transfer in flight keeps the tracker busy until done
    a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready || done)
        else $error("R9 shifter seen ready right after start");

endmodule

// File: rtl/vfd_scan_fsm.sv
module vfd_scan_fsm
    import vfd_scan_pkg::*;
#(
    parameter int SETTLE_CYC = 63,
    parameter int LATCH_CYC  = 75,
    parameter int GCLK_CYC   = 25,
    parameter int TOKEN      = 2,
    parameter int STEP_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              expired,
    input  logic              ready,
    input  logic [STEP_W-1:0] step,
    output logic              advance,
    output logic              stall,
    output logic              grid_blank,
    output logic              bank1_blank,
    output logic              bank2_blank,
    output logic              latch,
    output logic              grid_clk,
    output logic              grid_data,
    output logic              anode_start
);

    localparam int PH_MAX = max_of3(SETTLE_CYC, LATCH_CYC, GCLK_CYC);
    localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
    localparam logic [STEP_W-1:0] TOKEN_LAST = STEP_W'(TOKEN);

    scan_state_e       state_q, state_d;
    logic [PH_W-1:0]   ph_q, ph_d;
    logic              odd_step;

    function automatic logic [PH_W-1:0] ph_init(input scan_state_e s);
        case (s)
            SQ_MASK, SQ_SELECT:     ph_init = PH_W'(SETTLE_CYC - 1);
            SQ_LATCH:               ph_init = PH_W'(LATCH_CYC - 1);
            SQ_GCLK_LO, SQ_GCLK_HI: ph_init = PH_W'(GCLK_CYC - 1);
            default:                ph_init = '0;
        endcase
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:    state_d = SQ_MASK;
            SQ_MASK:    if (ph_q == '0) state_d = SQ_LATCH;
            SQ_LATCH:   if (ph_q == '0) state_d = SQ_GCLK_LO;
            SQ_GCLK_LO: if (ph_q == '0) state_d = SQ_GCLK_HI;
            SQ_GCLK_HI: if (ph_q == '0) state_d = SQ_SELECT;
            SQ_SELECT:  if (ph_q == '0) state_d = SQ_SHOW;
            SQ_SHOW:    state_d = SQ_WAIT;
            SQ_WAIT:    if (expired && ready) state_d = SQ_MASK;
            default:    state_d = SQ_IDLE;
        endcase
        if (!enable) begin
            state_d = SQ_IDLE;
        end
    end

    always_comb begin
        if (state_d != state_q) begin
            ph_d = ph_init(state_d);
        end else if (ph_q != '0) begin
            ph_d = ph_q - 1'b1;
        end else begin
            ph_d = ph_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            ph_q    <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
        end
    end

    assign advance  = (state_d == SQ_MASK) && (state_q != SQ_MASK);
    assign stall    = (state_q == SQ_WAIT) && expired && !ready;
    assign odd_step = step[0];

    always_comb begin
        grid_blank  = 1'b1;
        bank1_blank = 1'b1;
        bank2_blank = 1'b1;
        latch       = 1'b0;
        grid_clk    = 1'b1;
        anode_start = 1'b0;
        grid_data   = (state_q != SQ_IDLE) && (step != '0) && (step <= TOKEN_LAST);
        unique case (state_q)
            SQ_LATCH:   latch = 1'b1;
            SQ_GCLK_LO: grid_clk = 1'b0;
            SQ_SELECT: begin
                bank1_blank = !odd_step;
                bank2_blank = odd_step;
            end
            SQ_SHOW: begin
                grid_blank  = 1'b0;
                bank1_blank = !odd_step;
                bank2_blank = odd_step;
                anode_start = 1'b1;
            end
            SQ_WAIT: begin
                grid_blank  = 1'b0;
                bank1_blank = !odd_step;
                bank2_blank = odd_step;
            end
            default: ;
        endcase
    end

    // R7: the shifter start is a single-cycle pulse
    a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        anode_start |=> !anode_start)
        else $error("R7 start pulse too long");

    // R5: grid clock only falls while everything is masked
    a_r5_gclk_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grid_clk) |-> grid_blank && bank1_blank && bank2_blank)
        else $error("R5 grid clock edge while unmasked");

    // R9: no step advance while the shifter is still busy
    a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && !ready && enable) |=> state_q == SQ_WAIT)
        else $error("R9 step advanced while shifter busy");

    // R6: a bank is already chosen when the grid mask drops
    a_r6_select_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grid_blank) |-> (bank1_blank != bank2_blank) && $past(bank1_blank != bank2_blank))
        else $error("R6 mask released before bank select");

endmodule

// File: rtl/vfd_scan_seq.sv
module vfd_scan_seq #(
    parameter int STEPS      = 64,
    parameter int TOKEN      = 2,
    parameter int TIMER_W    = 16,
    parameter int FRAME_W    = 16,
    parameter int SETTLE_CYC = 63,
    parameter int LATCH_CYC  = 75,
    parameter int GCLK_CYC   = 25,
    localparam int STEP_W    = $clog2(STEPS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [TIMER_W-1:0] step_reload,
    input  logic               anode_done,
    output logic               anode_start,
    output logic               grid_blank,
    output logic               bank1_blank,
    output logic               bank2_blank,
    output logic               latch,
    output logic               grid_clk,
    output logic               grid_data,
    output logic               vsync,
    output logic [FRAME_W-1:0] frame_count,
    output logic [STEP_W-1:0]  step_idx,
    output logic               overrun
);

    logic advance;
    logic stall;
    logic expired;
    logic ready;

    vfd_step_timer #(
        .TIMER_W (TIMER_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .load    (advance),
        .reload  (step_reload),
        .expired (expired)
    );

    vfd_step_counter #(
        .STEPS   (STEPS),
        .STEP_W  (STEP_W),
        .FRAME_W (FRAME_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .advance (advance),
        .step_q  (step_idx),
        .vsync_q (vsync),
        .frame_q (frame_count)
    );

    vfd_anode_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (anode_start),
        .done    (anode_done),
        .stall   (stall),
        .ready   (ready),
        .overrun (overrun)
    );

    vfd_scan_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .LATCH_CYC  (LATCH_CYC),
        .GCLK_CYC   (GCLK_CYC),
        .TOKEN      (TOKEN),
        .STEP_W     (STEP_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .expired     (expired),
        .ready       (ready),
        .step        (step_idx),
        .advance     (advance),
        .stall       (stall),
        .grid_blank  (grid_blank),
        .bank1_blank (bank1_blank),
        .bank2_blank (bank2_blank),
        .latch       (latch),
        .grid_clk    (grid_clk),
        .grid_data   (grid_data),
        .anode_start (anode_start)
    );

    // R1: one cycle after disable every line is in the dark state
    a_r1_safe_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> grid_blank && bank1_blank && bank2_blank && !latch && !anode_start)
        else $error("R1 lines not safe while disabled");

    // R6: the two anode banks are never lit together
    a_r6_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bank1_blank && !bank2_blank))
        else $error("R6 both banks unblanked");

    // R4: latching only happens fully masked
    a_r4_latch_masked: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> grid_blank && bank1_blank && bank2_blank)
        else $error("R4 latch while unmasked");

endmodule

// File: tb/tb_vfd_scan_seq.sv
`timescale 1ns/1ps
module tb_vfd_scan_seq;

    localparam int STEPS = 64;
    localparam int TOKEN = 2;
    localparam int SET   = 2;
    localparam int LAT   = 3;
    localparam int GCK   = 2;
    localparam int TW    = 8;
    localparam int FW    = 8;
    localparam int SW    = $clog2(STEPS + 1);
    localparam int SEQ   = 2 * SET + LAT + 2 * GCK + 1;
    localparam int E_LAT  = SET;
    localparam int E_LO   = SET + LAT;
    localparam int E_HI   = E_LO + GCK;
    localparam int E_SEL  = E_HI + GCK;
    localparam int E_SHOW = E_SEL + SET;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic anode_done = 1'b0;
    logic [TW-1:0] step_reload = '0;
    logic anode_start, grid_blank, bank1_blank, bank2_blank;
    logic latch, grid_clk, grid_data, vsync, overrun;
    logic [FW-1:0] frame_count;
    logic [SW-1:0] step_idx;

    vfd_scan_seq #(
        .STEPS (STEPS), .TOKEN (TOKEN), .TIMER_W (TW), .FRAME_W (FW),
        .SETTLE_CYC (SET), .LATCH_CYC (LAT), .GCLK_CYC (GCK)
    ) dut (
        .clk (clk), .rst_n (rst_n), .enable (enable), .step_reload (step_reload),
        .anode_done (anode_done), .anode_start (anode_start), .grid_blank (grid_blank),
        .bank1_blank (bank1_blank), .bank2_blank (bank2_blank), .latch (latch),
        .grid_clk (grid_clk), .grid_data (grid_data), .vsync (vsync),
        .frame_count (frame_count), .step_idx (step_idx), .overrun (overrun)
    );

    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc = 0;
    bit running = 1'b0;
    int k = 0, per = 1, exp_step = 0, exp_frame = 0, dly = 1, sh_cnt = 0, last_obs = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic cycle();
        bit exp_vs, sel, odd;
        @(negedge clk);
        cyc++;
        exp_vs = 1'b0;
        if (running) begin
            k++;
            if (k == per) begin
                k = 0;
                if (exp_step == STEPS) begin
                    exp_vs = 1'b1;
                    exp_frame++;
                end
                exp_step = (exp_step == STEPS) ? 1 : exp_step + 1;
                if (last_obs != 0)
                    chk("R2 step order", int'(step_idx), (last_obs == STEPS) ? 1 : last_obs + 1);
            end
            sel = (k >= E_SEL);
            odd = exp_step[0];
            chk("R8 step timing", int'(step_idx), exp_step);
            chk("R3 grid token", int'(grid_data), int'(exp_step <= TOKEN));
            chk("R4 latch", int'(latch), int'(k >= E_LAT && k < E_LO));
            chk("R5 grid clock", int'(grid_clk), int'(!(k >= E_LO && k < E_HI)));
            chk("R6 bank1 blank", int'(bank1_blank), sel ? int'(!odd) : 1);
            chk("R6 bank2 blank", int'(bank2_blank), sel ? int'(odd) : 1);
            chk("R7 grid blank", int'(grid_blank), int'(k < E_SHOW));
            chk("R7 anode start", int'(anode_start), int'(k == E_SHOW));
        end else begin
            chk("R1 idle grid blank", int'(grid_blank), 1);
            chk("R1 idle bank1", int'(bank1_blank), 1);
            chk("R1 idle bank2", int'(bank2_blank), 1);
            chk("R1 idle latch", int'(latch), 0);
            chk("R1 idle gclk", int'(grid_clk), 1);
            chk("R1 idle gdata", int'(grid_data), 0);
            chk("R1 idle start", int'(anode_start), 0);
            chk("R1 idle step", int'(step_idx), 0);
        end
        chk("R10 vsync", int'(vsync), int'(exp_vs));
        chk("R10 frame count", int'(frame_count), exp_frame);
        last_obs = int'(step_idx);
        // anode shifter model: done pulse dly cycles after start
        anode_done = 1'b0;
        if (sh_cnt > 0) begin
            sh_cnt--;
            if (sh_cnt == 0) anode_done = 1'b1;
        end
        if (anode_start) sh_cnt = dly;
    endtask

    task automatic run_phase(input int rl, input int d, input int nsteps, input int extra);
        step_reload = TW'(rl);
        dly = d;
        per = ((rl > SEQ - 1 + d) ? rl : SEQ - 1 + d) + 1;
        enable = 1'b1;
        running = 1'b1;
        exp_step = 0;
        last_obs = 0;
        k = per - 1;
        repeat (nsteps * per + extra) cycle();
        enable = 1'b0;
        running = 1'b0;
        exp_step = 0;
        repeat (3) cycle();
        sh_cnt = 0;
    endtask

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog: actual hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) cycle();
        chk("R9 overrun after reset", int'(overrun), 0);
        chk("R10 frame count after reset", int'(frame_count), 0);

        // R8 timer-limited: reload 20, done 4 cycles after start, 130 steps
        run_phase(20, 4, 130, 0);
        chk("R10 two frame wraps", int'(frame_count), 2);
        chk("R9 no overrun slow timer", int'(overrun), 0);

        // R8 sequence-limited: reload below the fixed sequence length
        run_phase(5, 1, 70, 0);
        chk("R10 third frame wrap", int'(frame_count), 3);
        chk("R9 no overrun fast done", int'(overrun), 0);

        // R1 disable in the middle of the latch pulse
        run_phase(20, 4, 0, E_LAT + 2);
        chk("R1 frame kept over disable", int'(frame_count), 3);
        chk("R9 no overrun after abort", int'(overrun), 0);

        // R9 shifter slower than the timer: step waits and overrun sticks
        run_phase(15, 10, 66, 0);
        chk("R9 overrun set", int'(overrun), 1);
        chk("R10 fourth frame wrap", int'(frame_count), 4);
        repeat (5) cycle();
        chk("R9 overrun still set", int'(overrun), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule